// File: doc/BRIEF.md
# Byte Sum-of-Absolute-Differences Accumulator

This unit takes two 32-bit words and treats each one as four unsigned bytes. For each byte position it takes the absolute difference of the two bytes. It then adds the four differences into one small sum. When the caller asks for it, a 32-bit accumulator value is added to that sum, wrapping modulo 2^32. This is the inner step of block-matching and motion-search loops, where a running total of pixel differences is carried from one word to the next.

The caller presents one operation per cycle with `in_valid`. It decodes upstream whether the accumulating form is wanted: the non-accumulating form is chosen when the accumulator register index is 15. The caller passes that choice in as `acc_en`. The result is registered. It appears one cycle after the request and stays in place until the next request.

Top module: `sad_accum`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` in a cycle equals `in_valid` in the previous cycle, so back-to-back requests give back-to-back results.
- R3: Lane i takes bits [8i+7:8i] of `a` and of `b`, for i = 0 to 3. Its difference is the unsigned value |a_i - b_i|, which is the same whichever operand is larger.
- R4: With `acc_en` = 0, `result` is the sum of the four lane differences, zero-extended to 32 bits. The largest value, 1020 (0x3FC), appears without overflow, and bits [31:10] are 0.
- R5: With `acc_en` = 1, `result` is (lane sum + `acc`) mod 2^32.
- R6: In a cycle after one where `in_valid` was 0, `result` keeps its previous value.
- R7: With `acc_en` = 0, the value on `acc` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe: the operands are taken this cycle |
| a | input | 32 | First operand, four unsigned bytes |
| b | input | 32 | Second operand, four unsigned bytes |
| acc | input | 32 | Accumulator value, added when `acc_en` is 1 |
| acc_en | input | 1 | 1 selects the accumulating form |
| result | output | 32 | Registered sum of differences, plus the accumulator when selected |
| out_valid | output | 1 | High one cycle after `in_valid` |

## Verification
The bench builds the block with its default four lanes of eight bits. That width makes two kinds of edge case easy to reach. The first is single-byte stimulus, which proves each lane reads its own bit field in both difference directions. The second is the all-0xFF against all-0x00 pattern, which drives the sum to its 1020 ceiling. With 32-bit accumulator inputs near 2^32, the modulo wrap of the accumulating form is also checked directly. A behavioural model computes every expected word with plain integer arithmetic. Its queue covers both idle cycles and random traffic, and it is compared with the design on every clock.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned LANES_DEF  = 4;

  // Bits needed to hold LANES values of LANE_W bits each without overflow.
  function automatic int unsigned sum_width(input int unsigned lane_w,
                                            input int unsigned lanes);
    return lane_w + $clog2(lanes);
  endfunction
endpackage

// File: rtl/sad_lane.sv
module sad_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] diff,
  output logic         x_above
);
  function automatic logic [W-1:0] abs_gap(input logic [W-1:0] p,
                                           input logic [W-1:0] q);
    return (p > q) ? (p - q) : (q - p);
  endfunction

  assign x_above = (x > y);
  assign diff    = abs_gap(x, y);

  // R3: the difference is zero exactly when the two bytes match
  always_comb begin
    a_r3_zero_iff_equal: assert ((diff == '0) == (x == y));
  end
endmodule

// File: rtl/sad_reduce.sv
module sad_reduce #(
  parameter int unsigned W  = 8,
  parameter int unsigned N  = 4,
  parameter int unsigned SW = 10
) (
  input  logic [N*W-1:0] diffs,
  output logic [SW-1:0]  sum
);
  localparam logic [SW-1:0] SUM_CEIL = SW'(N * ((1 << W) - 1));

  function automatic logic [SW-1:0] add_lanes(input logic [N*W-1:0] d);
    logic [SW-1:0] acc_v;
    acc_v = '0;
    for (int i = 0; i < N; i++) acc_v = acc_v + SW'(d[i*W +: W]);
    return acc_v;
  endfunction

  assign sum = add_lanes(diffs);

  // R4: the reduction never goes above the N * (2^W - 1) ceiling
  always_comb begin
    a_r4_no_overflow: assert (sum <= SUM_CEIL);
  end
endmodule

// File: rtl/sad_stage.sv
module sad_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          q_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

  // R2: each request produces a valid result one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !q_valid);
  // R6: the output word holds while no request arrives
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/sad_accum.sv
module sad_accum
  import sad_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES*LANE_W-1:0] b,
  input  logic [LANES*LANE_W-1:0] acc,
  input  logic                    acc_en,
  output logic [LANES*LANE_W-1:0] result,
  output logic                    out_valid
);
  localparam int unsigned DW = LANES * LANE_W;
  localparam int unsigned SW = sum_width(LANE_W, LANES);

  logic [DW-1:0]    lane_diffs;
  logic [LANES-1:0] lane_a_above;
  logic [SW-1:0]    lane_sum;
  logic [DW-1:0]    sum_wide;
  logic [DW-1:0]    next_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sad_lane #(.W(LANE_W)) i_lane (
      .x      (a[g*LANE_W +: LANE_W]),
      .y      (b[g*LANE_W +: LANE_W]),
      .diff   (lane_diffs[g*LANE_W +: LANE_W]),
      .x_above(lane_a_above[g])
    );
  end

  sad_reduce #(.W(LANE_W), .N(LANES), .SW(SW)) i_reduce (
    .diffs(lane_diffs),
    .sum  (lane_sum)
  );

  function automatic logic [DW-1:0] combine(input logic [DW-1:0] s,
                                            input logic [DW-1:0] c,
                                            input logic          en);
    return en ? (s + c) : s;
  endfunction

  assign sum_wide  = DW'(lane_sum);
  assign next_word = combine(sum_wide, acc, acc_en);

  sad_stage #(.DW(DW)) i_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_valid),
    .d      (next_word),
    .q      (result),
    .q_valid(out_valid)
  );

  // R4/R7: a non-accumulating result never reaches the high bits
  a_r7_plain_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_en) |=> (result[DW-1:SW] == '0));
  // R3: lane differences never exceed the larger of the two bytes
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      a_r3_lane_bound: assert (lane_diffs[i*LANE_W +: LANE_W] <=
        (lane_a_above[i] ? a[i*LANE_W +: LANE_W] : b[i*LANE_W +: LANE_W]));
    end
  end
endmodule

// File: tb/test_sad_accum.sv
module test_sad_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a = '0, b = '0, acc = '0;
  logic        acc_en = 1'b0;
  logic [31:0] result;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [31:0] exp_q[$];
  bit        exp_v;
  bit [31:0] exp_r;

  always #10 clk = ~clk;

  sad_accum i_sad_accum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .acc(acc), .acc_en(acc_en), .result(result), .out_valid(out_valid)
  );

  function automatic bit [31:0] model(bit [31:0] x, bit [31:0] y,
                                      bit [31:0] c, bit en);
    longint total = 0;
    for (int k = 0; k < 4; k++) begin
      int p = (x >> (8 * k)) & 255;
      int q = (y >> (8 * k)) & 255;
      total += (p >= q) ? (p - q) : (q - p);
    end
    if (en) total += c;
    return total[31:0];
  endfunction

  task automatic check(string tag, bit [31:0] act, bit [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Drive at a falling edge, let the rising edge capture, compare at the next falling edge.
  task automatic step(string tag, bit v, bit [31:0] x, bit [31:0] y,
                      bit [31:0] c, bit en);
    in_valid = v; a = x; b = y; acc = c; acc_en = en;
    if (v) exp_q.push_back(model(x, y, c, en));
    @(posedge clk);
    exp_v = v;
    if (v) exp_r = exp_q.pop_front();
    @(negedge clk);
    check({tag, " valid"}, {31'b0, out_valid}, {31'b0, exp_v});
    check(tag, result, exp_r);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
  end

  initial begin
    exp_v = 0; exp_r = '0;
    @(negedge clk); @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 post-reset result", result, 32'd0);

    step("R3 equal bytes", 1, 32'h5A5A_1234, 32'h5A5A_1234, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step("R3 lane a>b", 1, 32'hFF << (8 * k), 0, 0, 0);
      step("R3 lane b>a", 1, 32'h03 << (8 * k), 32'h10 << (8 * k), 0, 0);
    end
    step("R4 ceiling", 1, 32'hFFFF_FFFF, 32'h0000_0000, 0, 0);
    step("R4 ceiling swapped", 1, 32'h00FF_00FF, 32'hFF00_FF00, 0, 0);
    step("R7 acc ignored", 1, 32'h1020_3040, 32'h0406_0102, 32'hDEAD_BEEF, 0);
    step("R5 accumulate", 1, 32'h1020_3040, 32'h0406_0102, 32'h0000_1000, 1);
    step("R5 wrap", 1, 32'h0000_0004, 32'h0, 32'hFFFF_FFFF, 1);
    step("R6 idle hold", 0, 32'hFFFF_FFFF, 0, 32'h1234_5678, 1);
    step("R6 idle hold 2", 0, 32'h0101_0101, 0, 0, 0);
    step("R2 back-to-back 1", 1, 32'h8080_8080, 32'h7F7F_7F7F, 5, 1);
    step("R2 back-to-back 2", 1, 32'h0000_0000, 32'h0102_0304, 0, 0);
    for (int n = 0; n < 300; n++) begin
      step("R2 random", ($urandom % 4) != 0, $urandom, $urandom, $urandom,
           $urandom % 2);
    end
    done = 1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule